// File: doc/BRIEF.md
# Byte-Serial Table-Driven CRC Engine

This block computes a cyclic redundancy check over a byte stream, absorbing one byte per clock cycle. Each step XORs the incoming byte with the top byte of the running remainder, uses that value to index a 256-entry table of precomputed remainders, and folds the table word into the remainder after shifting it left by eight bits. The table is built while the design elaborates, from the polynomial that the width parameter selects. No table contents are written out by hand.

A width parameter picks one of two variants. The 16-bit variant uses the ITU-T polynomial and produces an uninverted result. The 32-bit variant uses the common 32-bit polynomial, starts from all ones and inverts the result. Each byte also passes through to the output in the same cycle it enters the engine, so a transmitter downstream sees no added delay. The caller decides which bytes are covered: it strobes a clear at the start of each packet and marks the bytes to include with the valid input.

On receive, the caller feeds the payload and then the received check bytes, most significant byte first, and marks the last byte with the end-of-frame strobe. One cycle later the engine reports whether the remainder landed on the expected residue. A width parameter other than 16 or 32 is rejected at elaboration.

Top module: `crc_byte_engine`

## Requirements
- R1: While reset is held, and right after it is released, `crc_o` reads 0x0000 in the 16-bit variant and 0x00000000 in the 32-bit variant, and `chk_valid_o` and `chk_pass_o` are low.
- R2: A cycle with `clr_i` high reloads the remainder with its start value (0x0000 for 16-bit, 0xFFFFFFFF for 32-bit). If `valid_i` is high in the same cycle, the byte is not absorbed.
- R3: A cycle with `valid_i` high and `clr_i` low replaces the remainder r with (r << 8) XOR T[data XOR top byte of r]. T[i] is the remainder of i placed in the top byte and divided by the polynomial. `crc_o` shows the new value after the next rising edge.
- R4: A cycle with `valid_i` and `clr_i` both low leaves `crc_o` unchanged.
- R5: `data_o` equals `data_i` and `valid_o` equals `valid_i` in the same cycle, whatever the other inputs are.
- R6: The 16-bit variant uses polynomial 0x1021 with no output inversion. The ASCII bytes "123456789" after a clear give `crc_o` = 0x31C3.
- R7: The 32-bit variant uses polynomial 0x04C11DB7, starts from 0xFFFFFFFF and outputs the inverted remainder. "123456789" after a clear gives `crc_o` = 0xFC891918.
- R8: A cycle with `eof_i` high and `clr_i` low makes `chk_valid_o` high for the following cycle. In that cycle `chk_pass_o` is high exactly when the remainder, including any valid byte of the end-of-frame cycle, equals 0x0000 (16-bit) or 0xC704DD7B (32-bit, uninverted). A frame whose `crc_o` value is appended most significant byte first therefore passes.
- R9: `eof_i` in a cycle with `clr_i` high produces no check pulse, and neither check output is high without a preceding end-of-frame cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start of packet: reload the remainder |
| valid_i | input | 1 | Absorb `data_i` this cycle |
| data_i | input | 8 | Input byte |
| eof_i | input | 1 | Last byte of a frame: evaluate the check |
| data_o | output | 8 | Byte passed through, same cycle |
| valid_o | output | 1 | Valid passed through, same cycle |
| crc_o | output | CRC_W | Current CRC value, inverted in the 32-bit variant |
| chk_valid_o | output | 1 | One-cycle pulse after an end-of-frame cycle |
| chk_pass_o | output | 1 | Remainder matched the residue, qualified by `chk_valid_o` |

## Verification
The remainder register drives `crc_o` directly, so a wrong table word, shift or clear shows at the port on the first clock edge after the byte that exposes it. A wrong table word is exposed only by byte values that index it, so the bench must drive both random bytes and every boundary byte value. Each frame result reaches `chk_pass_o` one cycle after its end-of-frame strobe. A wrong residue constant or a misplaced check therefore shows as a frame carrying a correctly appended CRC that fails, or a corrupted frame that passes, on that one cycle. Both width variants run side by side against a bit-serial model, so a mistake in the elaboration-time table build shows up as a mismatch within one byte.

// File: rtl/crc_byte_pkg.sv
package crc_byte_pkg;

   // Polynomial selected by width (normal, MSB-first form)
   function automatic logic [31:0] poly_for(input int unsigned w);
      return (w == 32) ? 32'h04C1_1DB7 : 32'h0000_1021;
   endfunction

   function automatic logic [31:0] init_for(input int unsigned w);
      return (w == 32) ? 32'hFFFF_FFFF : 32'h0000_0000;
   endfunction

   function automatic logic [31:0] xorout_for(input int unsigned w);
      return (w == 32) ? 32'hFFFF_FFFF : 32'h0000_0000;
   endfunction

   // Remainder left after running the check bytes through (uninverted)
   function automatic logic [31:0] residue_for(input int unsigned w);
      return (w == 32) ? 32'hC704_DD7B : 32'h0000_0000;
   endfunction

   // One table word: idx placed in the top byte, divided over eight bit steps
   function automatic logic [31:0] lut_word(input int unsigned idx,
                                            input int unsigned w,
                                            input logic [31:0] poly);
      logic [31:0] r;
      r = 32'(idx) << (w - 8);
      for (int k = 0; k < 8; k++) begin
         if (r[w-1]) r = (r << 1) ^ poly;
         else        r = r << 1;
      end
      if (w < 32) r = r & ((32'h1 << w) - 32'h1);
      return r;
   endfunction

endpackage

// File: rtl/crc_lut_rom.sv
module crc_lut_rom #(
   parameter int unsigned W    = 16,
   parameter logic [31:0] POLY = 32'h0000_1021
) (
   input  logic [7:0]   idx_i,
   output logic [W-1:0] word_o
);
   localparam int unsigned ENTRIES = 256;

   logic [W-1:0] rom [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      localparam logic [31:0] WORD = crc_byte_pkg::lut_word(g, W, POLY);
      assign rom[g] = WORD[W-1:0];
   end

   assign word_o = rom[idx_i];

   // Entry 0 is always zero for any polynomial
   always_comb begin
      if (idx_i == 8'h00) assert (word_o == '0) else $error("p_lut_zero_r3");
   end
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
   parameter int unsigned W    = 16,
   parameter logic [31:0] POLY = 32'h0000_1021,
   parameter logic [31:0] INIT = 32'h0000_0000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         valid_i,
   input  logic [7:0]   data_i,
   output logic [W-1:0] crc_q,
   output logic [W-1:0] crc_nxt
);
   localparam logic [W-1:0] INIT_W = INIT[W-1:0];
   localparam int unsigned  TOP    = W - 1;

   logic [7:0]   lut_idx;
   logic [W-1:0] lut_word;
   logic [W-1:0] absorbed;

   assign lut_idx = data_i ^ crc_q[TOP -: 8];

   crc_lut_rom #(.W(W), .POLY(POLY)) u_lut (
      .idx_i  (lut_idx),
      .word_o (lut_word)
   );

   assign absorbed = (crc_q << 8) ^ lut_word;

   always_comb begin
      if (clr_i)        crc_nxt = INIT_W;
      else if (valid_i) crc_nxt = absorbed;
      else              crc_nxt = crc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_q <= INIT_W;
      else        crc_q <= crc_nxt;
   end

   p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_q == INIT_W));

   p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !valid_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_residue_check.sv
module crc_residue_check #(
   parameter int unsigned W   = 16,
   parameter logic [31:0] RES = 32'h0000_0000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         eof_i,
   input  logic         clr_i,
   input  logic [W-1:0] crc_nxt_i,
   output logic         chk_valid_o,
   output logic         chk_pass_o
);
   localparam logic [W-1:0] RES_W = RES[W-1:0];

   logic fire;
   assign fire = eof_i & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_valid_o <= 1'b0;
         chk_pass_o  <= 1'b0;
      end else begin
         chk_valid_o <= fire;
         chk_pass_o  <= fire && (crc_nxt_i == RES_W);
      end
   end

   p_pulse_follows_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && !clr_i) |=> chk_valid_o);

   p_no_pulse_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_i && clr_i) |=> !chk_valid_o);

   p_pass_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chk_pass_o |-> chk_valid_o);
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             valid_i,
   input  logic [7:0]       data_i,
   input  logic             eof_i,
   output logic [7:0]       data_o,
   output logic             valid_o,
   output logic [CRC_W-1:0] crc_o,
   output logic             chk_valid_o,
   output logic             chk_pass_o
);
   localparam logic [31:0]      POLY   = crc_byte_pkg::poly_for(CRC_W);
   localparam logic [31:0]      INIT   = crc_byte_pkg::init_for(CRC_W);
   localparam logic [31:0]      XOROUT = crc_byte_pkg::xorout_for(CRC_W);
   localparam logic [31:0]      RES    = crc_byte_pkg::residue_for(CRC_W);
   localparam logic [CRC_W-1:0] XOR_W  = XOROUT[CRC_W-1:0];
   localparam logic [CRC_W-1:0] INIT_W = INIT[CRC_W-1:0];

   if (CRC_W != 16 && CRC_W != 32) begin : g_bad_width
      $error("crc_byte_engine: CRC_W must be 16 or 32");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   // Zero-latency pass-through toward the transmitter
   assign data_o  = data_i;
   assign valid_o = valid_i;

   crc_state_reg #(.W(CRC_W), .POLY(POLY), .INIT(INIT)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .valid_i (valid_i),
      .data_i  (data_i),
      .crc_q   (crc_q),
      .crc_nxt (crc_nxt)
   );

   crc_residue_check #(.W(CRC_W), .RES(RES)) u_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .eof_i       (eof_i),
      .clr_i       (clr_i),
      .crc_nxt_i   (crc_nxt),
      .chk_valid_o (chk_valid_o),
      .chk_pass_o  (chk_pass_o)
   );

   if (CRC_W == 32) begin : g_inverted
      assign crc_o = crc_q ^ XOR_W;
   end else begin : g_plain
      assign crc_o = crc_q;
   end

   p_out_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_o == (INIT_W ^ XOR_W)));

   p_out_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !valid_i) |=> $stable(crc_o));
endmodule

// File: tb/crc_byte_engine_bench.sv
module crc_byte_engine_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, clr, vld, eof;
   logic [7:0]  din;
   logic [7:0]  do16, do32;
   logic        vo16, vo32;
   logic [15:0] crc16;
   logic [31:0] crc32;
   logic        cv16, cp16, cv32, cp32;

   int checks = 0;
   int errors = 0;
   logic [15:0] m16;
   logic [31:0] m32;

   crc_byte_engine #(.CRC_W(16)) u_crc_byte_engine (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .valid_i(vld), .data_i(din),
      .eof_i(eof), .data_o(do16), .valid_o(vo16), .crc_o(crc16),
      .chk_valid_o(cv16), .chk_pass_o(cp16));

   crc_byte_engine #(.CRC_W(32)) u_crc_byte_engine_w32 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .valid_i(vld), .data_i(din),
      .eof_i(eof), .data_o(do32), .valid_o(vo32), .crc_o(crc32),
      .chk_valid_o(cv32), .chk_pass_o(cp32));

   // Bit-serial reference, MSB first
   function automatic logic [31:0] bit_step(logic [31:0] r, logic [7:0] b,
                                            int w, logic [31:0] poly);
      for (int k = 0; k < 8; k++) begin
         logic fb;
         fb = r[w-1] ^ b[7-k];
         r  = r << 1;
         if (fb) r = r ^ poly;
      end
      if (w == 16) r[31:16] = '0;
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: called just after a falling edge
   task automatic cyc(logic c, logic v, logic [7:0] d, logic e);
      logic [15:0] n16;
      logic [31:0] n32;
      logic        fire;
      clr = c; vld = v; din = d; eof = e;
      #1;
      chk("R5", {do16, vo16}, {d, v});
      chk("R5", {do32, vo32}, {d, v});
      if (c) begin
         n16 = 16'h0000; n32 = 32'hFFFF_FFFF;                    // R2
      end else if (v) begin
         n16 = bit_step({16'h0, m16}, d, 16, 32'h1021) ;          // R3
         n32 = bit_step(m32, d, 32, 32'h04C1_1DB7);
      end else begin
         n16 = m16; n32 = m32;                                   // R4
      end
      fire = e & ~c;
      @(posedge clk); #1;
      chk(c ? "R2" : (v ? "R3" : "R4"), {16'h0, crc16}, {16'h0, n16});
      chk(c ? "R2" : (v ? "R3" : "R4"), crc32, ~n32);
      chk(fire ? "R8" : "R9", {cv16, cp16}, {fire, fire && (n16 == 16'h0)});
      chk(fire ? "R8" : "R9", {cv32, cp32}, {fire, fire && (n32 == 32'hC704_DD7B)});
      m16 = n16; m32 = n32;
      @(negedge clk);
   endtask

   initial begin
      logic [7:0] s [9];
      logic [15:0] f16;
      logic [31:0] f32;
      rst_n = 1'b0; clr = 0; vld = 0; din = 0; eof = 0;
      m16 = 16'h0; m32 = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", {16'h0, crc16}, 32'h0);
      chk("R1", crc32, 32'h0);
      chk("R1", {cv16, cp16, cv32, cp32}, 4'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", crc32, 32'h0);

      // R6 / R7 check string
      for (int i = 0; i < 9; i++) s[i] = 8'h31 + 8'(i);
      cyc(1, 0, 8'h00, 0);
      for (int i = 0; i < 9; i++) cyc(0, 1, s[i], 0);
      chk("R6", {16'h0, crc16}, 32'h0000_31C3);
      chk("R7", crc32, 32'hFC89_1918);
      // R4 idle hold with junk data
      cyc(0, 0, 8'hA5, 0);
      cyc(0, 0, 8'hFF, 0);
      chk("R4", crc32, 32'hFC89_1918);
      // R2 clear with a valid byte
      cyc(1, 1, 8'h5A, 0);
      chk("R2", {16'h0, crc16}, 32'h0);
      chk("R2", crc32, 32'h0);
      // Boundary bytes
      cyc(0, 1, 8'h00, 0);
      cyc(0, 1, 8'hFF, 0);
      cyc(0, 1, 8'h80, 0);

      // R8 16-bit good frame
      cyc(1, 0, 8'h00, 0);
      cyc(0, 1, 8'hC3, 0);
      cyc(0, 1, 8'h7E, 0);
      f16 = crc16;
      cyc(0, 1, f16[15:8], 0);
      cyc(0, 1, f16[7:0], 1);
      chk("R8", {31'h0, cp16}, 32'h1);
      // R8 32-bit good frame
      cyc(1, 0, 8'h00, 0);
      cyc(0, 1, 8'h11, 0);
      cyc(0, 1, 8'hEE, 0);
      cyc(0, 1, 8'h42, 0);
      f32 = crc32;
      cyc(0, 1, f32[31:24], 0);
      cyc(0, 1, f32[23:16], 0);
      cyc(0, 1, f32[15:8], 0);
      cyc(0, 1, f32[7:0], 1);
      chk("R8", {31'h0, cp32}, 32'h1);
      // R8 corrupted frame fails
      cyc(1, 0, 8'h00, 0);
      cyc(0, 1, 8'hC3, 0);
      cyc(0, 1, 8'h7E, 0);
      f16 = crc16 ^ 16'h0100;
      cyc(0, 1, f16[15:8], 0);
      cyc(0, 1, f16[7:0], 1);
      chk("R8", {31'h0, cp16}, 32'h0);
      // R9 eof with clear: no pulse
      cyc(0, 1, 8'h12, 0);
      cyc(1, 1, 8'h34, 1);
      chk("R9", {30'h0, cv16, cv32}, 32'h0);
      // eof without a byte
      cyc(0, 0, 8'h00, 1);

      // Random mix, fixed seed
      void'($urandom(32'd1234));
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[7:0] < 8'd10, r[15:8] > 8'd60, 8'($urandom), r[23:16] < 8'd20);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule